// File: doc/BRIEF.md
# Multi-Update PWM Compare Generator

This block produces one carrier-based PWM output from a symmetric triangle time base. A counter climbs from zero to a programmed period value and falls back to zero. A single active compare value decides where the output edges sit. When the count equals the compare value on the way up, the output goes high. When it equals it again on the way down, the output goes low. Zero and period events can add their own actions.

The compare value is written through a simple strobe-and-data port and takes effect in one of two ways. In buffered mode, a write lands in a holding register and moves to the active register only at the selected counter event: zero, period, or both. This allows at most two updates per carrier period and keeps every period consistent. In direct mode, a write replaces the active value on the next clock. A control loop can then rewrite the duty many times per carrier period, for example ten, and trade away the buffered guarantee.

Matching is by strict equality. A direct rewrite that moves the compare value across the current count, without the two ever being equal, therefore loses that edge for the rest of the period. Compare values at zero, or at or above the period, pin the output steadily high or low.

Top module: `pwm_multi_update`

## Requirements
- R1: After reset the count runs 0,1,…,P,P−1,…,1,0 with a period of 2P clocks. P is the period input, captured only in the cycle where the count is 0. `zero_strobe` is high exactly in cycles with count 0. `period_strobe` is high exactly in the cycle with count P.
- R2: For an active compare C with 0 < C < P, `cmp_up_strobe` is high in the rising-count cycle where count equals C, and `pwm_out` is high from the following cycle. `cmp_down_strobe` is high in the falling-count cycle where count equals C, and `pwm_out` is low from the following cycle. A steady C gives 2(P−C) high cycles per period.
- R3: With `direct_mode` = 1, a write replaces the active compare on the next clock. A write is accepted in every cycle, so ten or more writes per carrier period all take effect.
- R4: Edges fire only on exact equality. A direct write that moves C past the current count without equality yields no edge for the rest of that period.
- R5: With `direct_mode` = 0, writes go to a holding register. It is copied to the active compare only at a selected event. `load_sel` encoding: 0 = zero, 1 = period, 2 or 3 = both.
- R6: A load event and a write in the same cycle copy the old held value to the active compare, and the new write is stored in the holding register.
- R7: If the active compare is ≥ the captured period, `pwm_out` is low from the next cycle on. If it is 0 (and the period is nonzero), `pwm_out` is high. These clamps override zero and period actions.
- R8: `zero_act` and `period_act` encoding: 0 = none, 1 = clear, 2 = set, 3 = toggle. The action is applied to `pwm_out` in the next cycle, only when no compare action or clamp applies in that cycle.
- R9: While reset is low, `pwm_out` is 0 and the count is 0. The active and held compare values reset to all ones, so the output stays low until a smaller value is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_in | input | W | Carrier period P, captured at count zero |
| direct_mode | input | 1 | 1 = direct compare update, 0 = buffered |
| load_sel | input | 2 | Buffered load event: 0 zero, 1 period, 2/3 both |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_wdata | input | W | Compare write value |
| zero_act | input | 2 | Action at count zero: 0 none, 1 clear, 2 set, 3 toggle |
| period_act | input | 2 | Action at count P, same encoding |
| pwm_out | output | 1 | PWM output |
| zero_strobe | output | 1 | Count equals zero |
| period_strobe | output | 1 | Count equals period |
| cmp_up_strobe | output | 1 | Rising-count compare match |
| cmp_down_strobe | output | 1 | Falling-count compare match |

## Verification
Buffered updates are tried with each load-event choice, using a write placed mid-period. This separates zero-only from period-only from both-edge loading by when the new duty first appears. Direct updates are tried with a burst of ten writes per period to show every write lands next clock. A single write is then placed so that it jumps the compare back behind the count, which tells equality matching apart from greater-or-equal matching by the missing rising edge. Further patterns cover the compare values 0, P and above P with toggle actions armed, a write coinciding with a zero-event load, each nonzero zero and period action against a mid-range compare, and a period change made mid-period to show it waits for zero.

// File: rtl/pwm_mu_pkg.sv
package pwm_mu_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_CLR  = 2'd1,
    ACT_SET  = 2'd2,
    ACT_TGL  = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    LD_ZERO  = 2'd0,
    LD_PRD   = 2'd1,
    LD_BOTH  = 2'd2,
    LD_BOTHX = 2'd3
  } ld_e;

  function automatic logic apply_act(input logic [1:0] code, input logic cur);
    case (act_e'(code))
      ACT_CLR: apply_act = 1'b0;
      ACT_SET: apply_act = 1'b1;
      ACT_TGL: apply_act = ~cur;
      default: apply_act = cur;
    endcase
  endfunction

  function automatic logic zero_loads(input logic [1:0] sel);
    zero_loads = (ld_e'(sel) != LD_PRD);
  endfunction

  function automatic logic prd_loads(input logic [1:0] sel);
    prd_loads = (ld_e'(sel) != LD_ZERO);
  endfunction

endpackage

// File: rtl/pwm_tbase.sv
module pwm_tbase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] period_in,
  output logic [W-1:0] cnt,
  output logic [W-1:0] prd_q,
  output logic         dir_up,
  output logic         zro_evt,
  output logic         prd_evt
);

  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      prd_q  <= '0;
      dir_up <= 1'b1;
    end else if (cnt == '0) begin
      prd_q  <= period_in;
      dir_up <= 1'b1;
      cnt    <= (period_in == '0) ? '0 : ONE;
    end else if (dir_up) begin
      if (cnt >= prd_q) begin
        dir_up <= 1'b0;
        cnt    <= cnt - ONE;
      end else begin
        cnt    <= cnt + ONE;
      end
    end else begin
      cnt <= cnt - ONE;
    end
  end

  assign zro_evt = (cnt == '0);
  assign prd_evt = dir_up && (cnt != '0) && (cnt == prd_q);

endmodule

// File: rtl/pwm_cmp_reg.sv
module pwm_cmp_reg
  import pwm_mu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         direct_mode,
  input  logic [1:0]   load_sel,
  input  logic         zro_evt,
  input  logic         prd_evt,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  output logic [W-1:0] cmp_act,
  output logic [W-1:0] cmp_hold,
  output logic         load_evt
);

  assign load_evt = !direct_mode &&
                    ((zro_evt && zero_loads(load_sel)) ||
                     (prd_evt && prd_loads(load_sel)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_act  <= '1;
      cmp_hold <= '1;
    end else begin
      if (direct_mode && cmp_wr) cmp_act <= cmp_wdata;
      else if (load_evt)         cmp_act <= cmp_hold;
      if (cmp_wr)                cmp_hold <= cmp_wdata;
    end
  end

endmodule

// File: rtl/pwm_aq.sv
module pwm_aq
  import pwm_mu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] prd_q,
  input  logic         dir_up,
  input  logic [W-1:0] cmp_act,
  input  logic         zro_evt,
  input  logic         prd_evt,
  input  logic [1:0]   zero_act,
  input  logic [1:0]   period_act,
  output logic         pwm_out,
  output logic         cmp_up_evt,
  output logic         cmp_dn_evt,
  output logic         clamp_hi,
  output logic         clamp_lo
);

  logic in_range;
  logic hit;
  logic out_nxt;

  assign clamp_lo   = (cmp_act >= prd_q);
  assign clamp_hi   = !clamp_lo && (cmp_act == '0);
  assign in_range   = !clamp_lo && !clamp_hi;
  assign hit        = in_range && (cnt == cmp_act);
  assign cmp_up_evt = hit && dir_up;
  assign cmp_dn_evt = hit && !dir_up;

  always_comb begin
    if (clamp_lo)        out_nxt = 1'b0;
    else if (clamp_hi)   out_nxt = 1'b1;
    else if (cmp_up_evt) out_nxt = 1'b1;
    else if (cmp_dn_evt) out_nxt = 1'b0;
    else if (zro_evt)    out_nxt = apply_act(zero_act, pwm_out);
    else if (prd_evt)    out_nxt = apply_act(period_act, pwm_out);
    else                 out_nxt = pwm_out;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pwm_out <= 1'b0;
    else        pwm_out <= out_nxt;
  end

endmodule

// File: rtl/pwm_multi_update.sv
module pwm_multi_update #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] period_in,
  input  logic         direct_mode,
  input  logic [1:0]   load_sel,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic [1:0]   zero_act,
  input  logic [1:0]   period_act,
  output logic         pwm_out,
  output logic         zero_strobe,
  output logic         period_strobe,
  output logic         cmp_up_strobe,
  output logic         cmp_down_strobe
);

  logic [W-1:0] cnt;
  logic [W-1:0] prd_q;
  logic         dir_up;
  logic         zro_evt;
  logic         prd_evt;
  logic [W-1:0] cmp_act;
  logic [W-1:0] cmp_hold;
  logic         load_evt;
  logic         clamp_hi;
  logic         clamp_lo;
  logic         cmp_up_evt;
  logic         cmp_dn_evt;

  pwm_tbase #(.W(W)) u_tb (
    .clk(clk), .rst_n(rst_n), .period_in(period_in),
    .cnt(cnt), .prd_q(prd_q), .dir_up(dir_up),
    .zro_evt(zro_evt), .prd_evt(prd_evt)
  );

  pwm_cmp_reg #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .direct_mode(direct_mode), .load_sel(load_sel),
    .zro_evt(zro_evt), .prd_evt(prd_evt), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .cmp_act(cmp_act), .cmp_hold(cmp_hold), .load_evt(load_evt)
  );

  pwm_aq #(.W(W)) u_aq (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .prd_q(prd_q), .dir_up(dir_up),
    .cmp_act(cmp_act), .zro_evt(zro_evt), .prd_evt(prd_evt),
    .zero_act(zero_act), .period_act(period_act), .pwm_out(pwm_out),
    .cmp_up_evt(cmp_up_evt), .cmp_dn_evt(cmp_dn_evt),
    .clamp_hi(clamp_hi), .clamp_lo(clamp_lo)
  );

  assign zero_strobe     = zro_evt;
  assign period_strobe   = prd_evt;
  assign cmp_up_strobe   = cmp_up_evt;
  assign cmp_down_strobe = cmp_dn_evt;

endmodule

// File: rtl/pwm_multi_update_chk.sv
module pwm_multi_update_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         direct_mode,
  input logic         cmp_wr,
  input logic [W-1:0] cmp_wdata,
  input logic [W-1:0] cmp_act,
  input logic [W-1:0] prd_q,
  input logic         load_evt,
  input logic         zro_evt,
  input logic         prd_evt,
  input logic         cmp_up_evt,
  input logic         cmp_dn_evt,
  input logic         pwm_out
);

  assert_events_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({zro_evt, prd_evt, cmp_up_evt, cmp_dn_evt}));

  assert_period_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !zro_evt |=> $stable(prd_q));

  assert_up_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_up_evt |=> pwm_out);

  assert_down_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_dn_evt |=> !pwm_out);

  assert_direct_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_mode && cmp_wr) |=> (cmp_act == $past(cmp_wdata)));

  assert_rise_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwm_out) && !$past(zro_evt) && !$past(prd_evt))
      |-> ($past(cmp_up_evt) || ($past(cmp_act) == '0)));

  assert_buffered_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!direct_mode && !load_evt) |=> $stable(cmp_act));

  assert_clamp_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act >= prd_q) |=> !pwm_out);

endmodule

bind pwm_multi_update pwm_multi_update_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .direct_mode(direct_mode), .cmp_wr(cmp_wr),
  .cmp_wdata(cmp_wdata), .cmp_act(cmp_act), .prd_q(prd_q), .load_evt(load_evt),
  .zro_evt(zro_evt), .prd_evt(prd_evt), .cmp_up_evt(cmp_up_evt),
  .cmp_dn_evt(cmp_dn_evt), .pwm_out(pwm_out)
);

// File: tb/tb_pwm_multi_update.sv
`timescale 1ns/1ps
module tb_pwm_multi_update;

  localparam int W = 16;
  localparam int P = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] period_in = W'(P);
  logic         direct_mode = 1'b0;
  logic [1:0]   load_sel = 2'd0;
  logic         cmp_wr = 1'b0;
  logic [W-1:0] cmp_wdata = '0;
  logic [1:0]   zero_act = 2'd0;
  logic [1:0]   period_act = 2'd0;
  logic         pwm_out, zero_strobe, period_strobe, cmp_up_strobe, cmp_down_strobe;

  int n_checks = 0;
  int n_fails  = 0;
  bit track = 1'b0;

  always #2 clk = ~clk;

  pwm_multi_update #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .period_in(period_in), .direct_mode(direct_mode),
    .load_sel(load_sel), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .zero_act(zero_act), .period_act(period_act), .pwm_out(pwm_out),
    .zero_strobe(zero_strobe), .period_strobe(period_strobe),
    .cmp_up_strobe(cmp_up_strobe), .cmp_down_strobe(cmp_down_strobe)
  );

  task automatic ck(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference: phase within carrier period, triangle count derived from it.
  int m_ph = 0, m_P = 0, m_c = 65535, m_h = 65535;
  bit m_out = 1'b0;

  function automatic int m_cnt();
    return (m_ph <= m_P) ? m_ph : 2 * m_P - m_ph;
  endfunction
  function automatic bit m_lo(); return m_c >= m_P; endfunction
  function automatic bit m_hi(); return !m_lo() && m_c == 0; endfunction
  function automatic bit m_zro(); return m_ph == 0; endfunction
  function automatic bit m_prd(); return m_P != 0 && m_ph == m_P; endfunction
  function automatic bit m_up();
    return !m_lo() && !m_hi() && m_ph < m_P && m_cnt() == m_c;
  endfunction
  function automatic bit m_dn();
    return !m_lo() && !m_hi() && m_ph > m_P && m_cnt() == m_c;
  endfunction
  function automatic bit act(input int code, input bit cur);
    case (code)
      1: return 1'b0;
      2: return 1'b1;
      3: return !cur;
      default: return cur;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_P = 0; m_c = 65535; m_h = 65535; m_out = 1'b0;
    end else begin
      bit nxt;
      bit ld;
      if (m_lo())      nxt = 1'b0;
      else if (m_hi()) nxt = 1'b1;
      else if (m_up()) nxt = 1'b1;
      else if (m_dn()) nxt = 1'b0;
      else if (m_zro()) nxt = act(int'(zero_act), m_out);
      else if (m_prd()) nxt = act(int'(period_act), m_out);
      else nxt = m_out;
      ld = !direct_mode && ((m_zro() && load_sel != 2'd1) || (m_prd() && load_sel != 2'd0));
      if (direct_mode && cmp_wr) m_c = int'(cmp_wdata);
      else if (ld) m_c = m_h;
      if (cmp_wr) m_h = int'(cmp_wdata);
      if (m_ph == 0) begin
        m_P = int'(period_in);
        m_ph = (m_P == 0) ? 0 : 1;
      end else if (m_ph == 2 * m_P - 1) m_ph = 0;
      else m_ph = m_ph + 1;
      m_out = nxt;
    end
  end

  always @(negedge clk) begin
    if (rst_n && track) begin
      ck(zero_strobe == m_zro(), "R1 zero strobe", int'(zero_strobe), int'(m_zro()));
      ck(period_strobe == m_prd(), "R1 period strobe", int'(period_strobe), int'(m_prd()));
      ck(cmp_up_strobe == m_up(), "R2 up strobe", int'(cmp_up_strobe), int'(m_up()));
      ck(cmp_down_strobe == m_dn(), "R2 down strobe", int'(cmp_down_strobe), int'(m_dn()));
      ck(pwm_out == m_out, "R2 pwm_out", int'(pwm_out), int'(m_out));
    end
  end

  task automatic wr(input int v);
    cmp_wr = 1'b1; cmp_wdata = W'(v);
    @(negedge clk);
    cmp_wr = 1'b0;
  endtask

  task automatic to_zero();
    @(negedge clk);
    while (!zero_strobe) @(negedge clk);
  endtask

  task automatic measure_high(output int n);
    to_zero();
    n = 0;
    repeat (2 * P) begin
      if (pwm_out) n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    ck(pwm_out == 1'b0, "R9 out in reset", int'(pwm_out), 0);
    ck(zero_strobe == 1'b1, "R9 count zero in reset", int'(zero_strobe), 1);
    rst_n = 1'b1;
    track = 1'b1;
    repeat (3 * P) @(negedge clk);
    ck(pwm_out == 1'b0, "R9 reset compare all ones", int'(pwm_out), 0);
  endtask

  task automatic t_buffered(input int sel, input int c);
    int n;
    direct_mode = 1'b0; load_sel = 2'(sel);
    to_zero();
    repeat (7) @(negedge clk);
    wr(c);
    measure_high(n);
    measure_high(n);
    ck(n == 2 * (P - c), "R5 buffered duty", n, 2 * (P - c));
  endtask

  task automatic t_direct_burst();
    int n;
    direct_mode = 1'b1;
    to_zero();
    for (int k = 0; k < 10; k++) begin
      cmp_wr = 1'b1; cmp_wdata = W'(3 + (k * 7) % 15);
      repeat (4) @(negedge clk);
    end
    cmp_wr = 1'b0;
    wr(6);
    measure_high(n);
    ck(n == 2 * (P - 6), "R3 direct duty after burst", n, 2 * (P - 6));
  endtask

  task automatic t_skip();
    direct_mode = 1'b1;
    wr(15);
    to_zero();
    to_zero();
    repeat (13) @(negedge clk);
    wr(11);
    while (!zero_strobe) begin
      ck(pwm_out == 1'b0, "R4 skipped edge stays low", int'(pwm_out), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_same_cycle();
    int n;
    direct_mode = 1'b0; load_sel = 2'd0;
    to_zero();
    repeat (5) @(negedge clk);
    wr(8);
    to_zero();
    wr(12);
    n = 0;
    repeat (2 * P - 1) begin
      if (pwm_out) n++;
      @(negedge clk);
    end
    ck(n == 2 * (P - 8), "R6 old held value loaded", n, 2 * (P - 8));
    measure_high(n);
    ck(n == 2 * (P - 12), "R6 new write held then loaded", n, 2 * (P - 12));
  endtask

  task automatic t_clamp();
    int n;
    direct_mode = 1'b1; zero_act = 2'd3; period_act = 2'd3;
    wr(0);
    measure_high(n);
    ck(n == 2 * P, "R7 compare zero steady high", n, 2 * P);
    wr(P);
    measure_high(n);
    ck(n == 0, "R7 compare at period steady low", n, 0);
    wr(100);
    measure_high(n);
    ck(n == 0, "R7 compare above period steady low", n, 0);
    zero_act = 2'd0; period_act = 2'd0;
  endtask

  task automatic t_actions();
    int n;
    direct_mode = 1'b1;
    wr(10);
    zero_act = 2'd2;
    measure_high(n); measure_high(n);
    ck(n == 30, "R8 zero set", n, 30);
    zero_act = 2'd0; period_act = 2'd1;
    measure_high(n); measure_high(n);
    ck(n == 10, "R8 period clear", n, 10);
    period_act = 2'd3;
    measure_high(n); measure_high(n);
    ck(n == 10, "R8 period toggle", n, 10);
    period_act = 2'd0;
  endtask

  task automatic t_period_latch();
    int n;
    direct_mode = 1'b1;
    wr(5);
    to_zero();
    repeat (10) @(negedge clk);
    period_in = W'(30);
    n = 10;
    @(negedge clk); n++;
    while (!zero_strobe) begin @(negedge clk); n++; end
    ck(n == 2 * P, "R1 period waits for zero", n, 2 * P);
    n = 1;
    @(negedge clk);
    while (!zero_strobe) begin @(negedge clk); n++; end
    ck(n == 60, "R1 new period length", n, 60);
    period_in = W'(P);
    to_zero();
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    ck(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_buffered(0, 5);
    t_buffered(1, 9);
    t_buffered(2, 14);
    t_buffered(3, 4);
    t_direct_burst();
    t_skip();
    t_same_cycle();
    t_clamp();
    t_actions();
    t_period_latch();
    repeat (5) @(negedge clk);
    report();
  end

endmodule